// File: doc/BRIEF.md
# Queue-Fed I2C Bus Master

This block is a single-master I2C controller that software drives by pushing 10-bit command entries into a small transmit queue. Each entry carries a byte together with two flags that ask for a start condition before the byte and a stop condition after it. The first byte after a start is an address byte. Its bit 0 selects a read. In a read, every later entry is a pacing trigger: it clocks in one byte from the slave, which is placed in a receive queue. The SCL high and low times come from two registers counted in system clock cycles. A status word reports the queue levels, a missing acknowledge and the completion of a transaction. A control bit performs a one-cycle, self-clearing soft reset.

SCL and SDA are open-drain. The block drives an output enable for each line (1 pulls the line low) and reads SDA back. The bus engine is a state machine with these states. IDLE waits for an entry; while the bus is owned, SCL is held low. RS_LO and RS_HI release SDA and then SCL ahead of a repeated start. START pulls SDA low with SCL high. BIT_LO and BIT_HI are the two halves of each of the nine clocks of a byte. STOP_LO, STOP_HI and STOP_END produce the stop condition.

The transitions are as follows. IDLE goes to START for a start entry on a free bus, to RS_LO for a start entry on an owned bus, and to BIT_LO for a plain entry on an owned bus. RS_LO goes to RS_HI, then to START, then to BIT_LO. BIT_LO alternates with BIT_HI for nine clocks. After the ninth clock BIT_HI goes to STOP_LO if the entry asked for a stop or the byte was not acknowledged, and to IDLE otherwise. STOP_LO then goes to STOP_HI, to STOP_END and back to IDLE.

Top module: `fifo_i2c_master`

## Requirements
- R1: Register map by `reg_addr`: 0 = queue data (a write pushes a transmit entry; a read pops the receive queue), 1 = status, 2 = control, 3 = SCL high time, 4 = SCL low time. A transmit entry holds the byte in bits 7:0, a start request in bit 8 and a stop request in bit 9.
- R2: An entry with bit 8 set produces a start condition before its byte, or a repeated start if the bus is already owned. That byte goes out as the address, and its bit 0 = 1 selects a read.
- R3: Transmitted bytes go out MSB first. On the ninth clock SDA is released and the slave's acknowledge is sampled. An entry with bit 9 set is followed by a stop condition.
- R4: In a read, each later entry is a trigger whose bits 7:0 are ignored. It clocks in one byte MSB first and appends it to the receive queue. The master drives ACK (SDA low) on the ninth clock, except for a trigger with the stop flag, which gets a NACK (SDA released).
- R5: Status bits: 10 = transmit queue full, 9 = receive queue empty, 2 = no acknowledge, 0 = transaction done. Writing a 1 to status bit 0 clears the done flag.
- R6: Writing a 1 to control bit 8 starts a soft reset. The bit reads back as 1 for the cycle that follows and as 0 after that. The reset empties both queues, clears the status flags, returns the engine to IDLE and releases SCL and SDA.
- R7: The SCL high and low phases each last exactly the number of clock cycles held in the high and low time registers (10 bits each). Both registers read back as written.
- R8: The done flag is set when a stop condition completes, including for an address-only probe. The no-acknowledge flag is set when any transmitted byte is not acknowledged, and it stays set until a soft reset.
- R9: After a transmitted byte is not acknowledged, the master issues a stop and drops every entry still in the transmit queue.
- R10: Each queue holds 4 entries. A push into a full transmit queue is ignored. A read of an empty receive queue returns 0 and changes nothing.
- R11: While SCL is released, SDA changes only to form a start or a stop condition. After reset both lines stay released and no transfer begins until an entry is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at address 0) |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| scl_oe | output | 1 | SCL pull-low enable |
| sda_oe | output | 1 | SDA pull-low enable |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The hardest case to reach is an entry that is still queued when a no-acknowledge occurs mid-transfer. The bench fills the queue behind an address byte while that byte is still being clocked out. A slave model then refuses either the address or the first data byte, and the bench checks that no later byte ever appears on the bus. The full-queue case is reached the same way: five entries are pushed back to back while the engine is busy with the first one, so the queue is full before the engine takes the next entry, and a sixth push is then shown to vanish. A soft reset is also issued in the middle of a byte, and both lines must then be released.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    localparam int TXW       = 10;
    localparam int ENT_START = 8;
    localparam int ENT_STOP  = 9;

    localparam logic [2:0] A_DATA = 3'd0;
    localparam logic [2:0] A_STAT = 3'd1;
    localparam logic [2:0] A_CTRL = 3'd2;
    localparam logic [2:0] A_SCLH = 3'd3;
    localparam logic [2:0] A_SCLL = 3'd4;

    localparam int ST_TXFULL  = 10;
    localparam int ST_RXEMPTY = 9;
    localparam int ST_NACK    = 2;
    localparam int ST_DONE    = 0;
    localparam int CTRL_SRST  = 8;

    typedef enum logic [3:0] {
        S_IDLE, S_RS_LO, S_RS_HI, S_START, S_BIT_LO, S_BIT_HI,
        S_STOP_LO, S_STOP_HI, S_STOP_END
    } eng_state_t;
endpackage

// File: rtl/i2cm_fifo.sv
module i2cm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= step(wp);
            end
            if (do_pop) rp <= step(rp);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    // R10: a push into a full queue leaves it full and unchanged
    a_r10_full_push_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> full);
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
#(
    parameter int PW = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic [PW-1:0]  t_hi,
    input  logic [PW-1:0]  t_lo,
    input  logic           tx_valid,
    input  logic [TXW-1:0] tx_entry,
    output logic           tx_pop,
    output logic           rx_push,
    output logic [7:0]     rx_byte,
    output logic           ev_done,
    output logic           ev_nack,
    output logic           scl_oe,
    output logic           sda_oe,
    input  logic           sda_in
);
    eng_state_t    state, nxt;
    logic [PW-1:0] tmr;
    logic [3:0]    bitc;
    logic [7:0]    sh;
    logic          owned, rd_mode, receiving, cur_stop;
    logic          tmr_done, byte_end, miss_ack;

    assign tmr_done = (tmr == '0);
    assign byte_end = (state == S_BIT_HI) && tmr_done && (bitc == 4'd8);
    assign miss_ack = byte_end && !receiving && sda_in;

    function automatic logic [PW-1:0] load_of(input eng_state_t s,
                                              input logic [PW-1:0] hi,
                                              input logic [PW-1:0] lo);
        logic [PW-1:0] p;
        p = (s == S_RS_LO || s == S_BIT_LO || s == S_STOP_LO) ? lo : hi;
        return (p == '0) ? '0 : p - 1'b1;
    endfunction

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (tx_valid) begin
                if (tx_entry[ENT_START]) nxt = owned ? S_RS_LO : S_START;
                else if (owned)          nxt = S_BIT_LO;
            end
            S_RS_LO:    if (tmr_done) nxt = S_RS_HI;
            S_RS_HI:    if (tmr_done) nxt = S_START;
            S_START:    if (tmr_done) nxt = S_BIT_LO;
            S_BIT_LO:   if (tmr_done) nxt = S_BIT_HI;
            S_BIT_HI:   if (tmr_done) begin
                if (bitc != 4'd8)               nxt = S_BIT_LO;
                else if (cur_stop || miss_ack)  nxt = S_STOP_LO;
                else                            nxt = S_IDLE;
            end
            S_STOP_LO:  if (tmr_done) nxt = S_STOP_HI;
            S_STOP_HI:  if (tmr_done) nxt = S_STOP_END;
            S_STOP_END: if (tmr_done) nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE; tmr <= '0; bitc <= '0; sh <= '0;
            owned <= 1'b0; rd_mode <= 1'b0; receiving <= 1'b0; cur_stop <= 1'b0;
        end else if (clr) begin
            state <= S_IDLE; tmr <= '0; bitc <= '0; sh <= '0;
            owned <= 1'b0; rd_mode <= 1'b0; receiving <= 1'b0; cur_stop <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt != state)  tmr <= load_of(nxt, t_hi, t_lo);
            else if (!tmr_done) tmr <= tmr - 1'b1;
            if (state == S_IDLE && tx_valid) begin
                cur_stop <= tx_entry[ENT_STOP];
                bitc     <= '0;
                if (tx_entry[ENT_START]) begin
                    rd_mode   <= tx_entry[0];
                    receiving <= 1'b0;
                    sh        <= tx_entry[7:0];
                end else begin
                    receiving <= rd_mode;
                    sh        <= rd_mode ? 8'h00 : tx_entry[7:0];
                end
            end
            if (state == S_START && tmr_done) owned <= 1'b1;
            if (state == S_BIT_HI && tmr_done && bitc != 4'd8) begin
                sh   <= {sh[6:0], receiving ? sda_in : 1'b0};
                bitc <= bitc + 1'b1;
            end
            if (state == S_STOP_END && tmr_done) owned <= 1'b0;
        end
    end

    always_comb begin
        tx_pop  = (state == S_IDLE) && tx_valid;
        rx_push = byte_end && receiving;
        rx_byte = sh;
        ev_nack = miss_ack;
        ev_done = (state == S_STOP_END) && tmr_done;
        scl_oe  = 1'b0;
        sda_oe  = 1'b0;
        unique case (state)
            S_IDLE:     scl_oe = owned;
            S_RS_LO:    scl_oe = 1'b1;
            S_RS_HI:    ;
            S_START:    sda_oe = 1'b1;
            S_BIT_LO, S_BIT_HI: begin
                scl_oe = (state == S_BIT_LO);
                sda_oe = (bitc == 4'd8) ? (receiving && !cur_stop)
                                        : (!receiving && !sh[7]);
            end
            S_STOP_LO:  begin scl_oe = 1'b1; sda_oe = 1'b1; end
            S_STOP_HI:  sda_oe = 1'b1;
            S_STOP_END: ;
            default:    ;
        endcase
    end

    // R11: with SCL released on both edges, SDA moves only to form start/stop
    a_r11_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && !$past(clr) && (sda_oe != $past(sda_oe)))
        |-> (state == S_START || state == S_STOP_END));
    // R6: the cycle after a soft reset both lines are released
    a_r6_reset_releases: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> (!scl_oe && !sda_oe));
    // R4: bytes enter the receive queue only in a read phase
    a_r4_push_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> rd_mode);
endmodule

// File: rtl/fifo_i2c_master.sv
module fifo_i2c_master
    import i2cm_pkg::*;
#(
    parameter int PW         = 10,
    parameter int FIFO_DEPTH = 4,
    parameter int DW         = 16,
    parameter int HI_RST     = 250,
    parameter int LO_RST     = 250
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          scl_oe,
    output logic          sda_oe,
    input  logic          sda_in
);
    logic [PW-1:0]  t_hi, t_lo;
    logic           srst_busy, done_f, nack_f;
    logic           tx_full, tx_empty, tx_pop;
    logic [TXW-1:0] tx_head;
    logic           rx_full, rx_empty, rx_push;
    logic [7:0]     rx_byte, rx_dout;
    logic           ev_done, ev_nack;
    logic           wr_data, wr_stat, wr_ctrl;
    logic           unused_bits;

    assign wr_data     = reg_wr && (reg_addr == A_DATA);
    assign wr_stat     = reg_wr && (reg_addr == A_STAT);
    assign wr_ctrl     = reg_wr && (reg_addr == A_CTRL);
    assign unused_bits = ^{reg_wdata[DW-1:TXW], rx_full};

    i2cm_fifo #(.W(TXW), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(srst_busy || ev_nack),
        .push(wr_data), .din(reg_wdata[TXW-1:0]), .pop(tx_pop),
        .dout(tx_head), .full(tx_full), .empty(tx_empty));

    i2cm_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(srst_busy),
        .push(rx_push), .din(rx_byte), .pop(reg_rd && (reg_addr == A_DATA)),
        .dout(rx_dout), .full(rx_full), .empty(rx_empty));

    i2cm_engine #(.PW(PW)) u_eng (
        .clk(clk), .rst_n(rst_n), .clr(srst_busy),
        .t_hi(t_hi), .t_lo(t_lo),
        .tx_valid(!tx_empty), .tx_entry(tx_head), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_byte(rx_byte),
        .ev_done(ev_done), .ev_nack(ev_nack),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_hi      <= PW'(HI_RST);
            t_lo      <= PW'(LO_RST);
            srst_busy <= 1'b0;
            done_f    <= 1'b0;
            nack_f    <= 1'b0;
        end else begin
            srst_busy <= wr_ctrl && reg_wdata[CTRL_SRST];
            if (reg_wr && reg_addr == A_SCLH) t_hi <= reg_wdata[PW-1:0];
            if (reg_wr && reg_addr == A_SCLL) t_lo <= reg_wdata[PW-1:0];
            if (srst_busy) begin
                done_f <= 1'b0;
                nack_f <= 1'b0;
            end else begin
                if (ev_done)                         done_f <= 1'b1;
                else if (wr_stat && reg_wdata[ST_DONE]) done_f <= 1'b0;
                if (ev_nack) nack_f <= 1'b1;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_DATA: if (!rx_empty) reg_rdata[7:0] = rx_dout;
            A_STAT: begin
                reg_rdata[ST_TXFULL]  = tx_full;
                reg_rdata[ST_RXEMPTY] = rx_empty;
                reg_rdata[ST_NACK]    = nack_f;
                reg_rdata[ST_DONE]    = done_f;
            end
            A_CTRL: reg_rdata[CTRL_SRST] = srst_busy;
            A_SCLH: reg_rdata[PW-1:0] = t_hi;
            A_SCLL: reg_rdata[PW-1:0] = t_lo;
            default: reg_rdata = '0;
        endcase
    end

    // R5: a clear write with no competing completion leaves done low
    a_r5_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && reg_wdata[ST_DONE] && !ev_done && !srst_busy) |=> !done_f);
    // R9: a missed acknowledge empties the transmit queue
    a_r9_flush_on_nack: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nack |=> tx_empty);
    // R8: no-acknowledge stays set until a soft reset
    a_r8_nack_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (nack_f && !srst_busy) |=> nack_f);
endmodule

// File: tb/sim_fifo_i2c_master.sv
module sim_fifo_i2c_master;
    localparam logic [6:0] SADDR = 7'h2C;
    localparam int NVEC = 6;
    // {addr[15:9], data[8:1], expect_nack[0]}
    localparam logic [15:0] VEC [NVEC] = '{
        {7'h2C, 8'h00, 1'b0}, {7'h2C, 8'hFF, 1'b0}, {7'h2C, 8'hA5, 1'b0},
        {7'h2C, 8'h5A, 1'b0}, {7'h13, 8'h3C, 1'b1}, {7'h2D, 8'h81, 1'b1}};

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        scl_oe, sda_oe;
    logic        s_drv;
    wire         scl_ln = !scl_oe;
    wire         sda_ln = !(sda_oe || s_drv);

    fifo_i2c_master u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_ln));

    int nchk = 0, nfail = 0;

    function automatic logic [7:0] rd_pat(input int i);
        return 8'(8'h3C + 8'(i) * 8'h29);
    endfunction

    // slave model and line monitor
    logic       p_scl = 1'b1, p_sda = 1'b1;
    logic       active, addr_ph, rdm, after_addr, mack, force_nack, slv_clr;
    int         bitn, rd_idx, wcount, mcount, n_start, run, hi_len, lo_len;
    logic [7:0] sh, txb;
    logic [7:0] wlog [16];
    logic       mlog [16];

    initial begin
        force_nack = 1'b0; slv_clr = 1'b0;
        run = 1; hi_len = 0; lo_len = 0;
    end

    always @(posedge clk) begin
        p_scl <= scl_ln;
        p_sda <= sda_ln;
        if (scl_ln == p_scl) run <= run + 1;
        else begin
            if (p_scl) hi_len <= run; else lo_len <= run;
            run <= 1;
        end
        if (!rst_n || slv_clr) begin
            active <= 0; addr_ph <= 0; rdm <= 0; after_addr <= 0; mack <= 1;
            s_drv <= 0; bitn <= 0; rd_idx <= 0; wcount <= 0; mcount <= 0;
            n_start <= 0; sh <= 0; txb <= 0;
        end else if (p_scl && scl_ln && p_sda && !sda_ln) begin
            n_start <= n_start + 1; active <= 1; addr_ph <= 1; rdm <= 0;
            bitn <= 0; s_drv <= 0; rd_idx <= 0;
        end else if (p_scl && scl_ln && !p_sda && sda_ln) begin
            active <= 0; s_drv <= 0;
        end else if (active && !p_scl && scl_ln) begin
            if (bitn < 8) sh <= {sh[6:0], sda_ln}; else mack <= sda_ln;
            bitn <= bitn + 1;
        end else if (active && p_scl && !scl_ln) begin
            if (bitn == 8) begin
                if (addr_ph) begin
                    addr_ph <= 0;
                    if (sh[7:1] == SADDR) begin
                        s_drv <= 1; rdm <= sh[0]; after_addr <= 1;
                    end else begin
                        s_drv <= 0; active <= 0;
                    end
                end else if (rdm) s_drv <= 0;
                else begin
                    if (wcount < 16) wlog[wcount] <= sh;
                    wcount <= wcount + 1;
                    s_drv <= !force_nack;
                end
            end else if (bitn == 9) begin
                bitn <= 0;
                if (rdm && !after_addr) begin
                    if (mcount < 16) mlog[mcount] <= mack;
                    mcount <= mcount + 1;
                end
                if (rdm && (after_addr || !mack)) begin
                    txb <= rd_pat(rd_idx);
                    s_drv <= !rd_pat(rd_idx)[7];
                    rd_idx <= rd_idx + 1;
                end else s_drv <= 0;
                after_addr <= 0;
            end else if (bitn >= 1 && bitn <= 7 && rdm && !addr_ph) begin
                s_drv <= !txb[7 - bitn];
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic wait_done(input string tag);
        logic [15:0] s;
        s = 0;
        for (int i = 0; i < 20000 && !s[0]; i++) rd(3'd1, s);
        if (!s[0]) chk({tag, " done timeout"}, 0, 1);
    endtask

    task automatic soft_reset();
        wr(3'd2, 16'h0100);
        @(negedge clk);
        @(negedge clk); slv_clr = 1;
        @(negedge clk); slv_clr = 0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (50) @(negedge clk);
        // R11 idle after reset, R5/R1 reset status
        chk("R11 lines released after reset", {30'd0, scl_oe, sda_oe}, 0);
        chk("R11 no start without entry", n_start, 0);
        rd(3'd1, v); chk("R5 reset status", v, 16'h0200);
        rd(3'd2, v); chk("R6 reset control", v, 0);
        rd(3'd0, v); chk("R10 empty rx read is zero", v, 0);

        wr(3'd3, 16'd4); wr(3'd4, 16'd4);
        rd(3'd3, v); chk("R7 high time readback", v, 4);
        rd(3'd4, v); chk("R7 low time readback", v, 4);

        // table walk: single-byte writes, R1 R2 R3 R8 R9
        for (int k = 0; k < NVEC; k++) begin
            soft_reset();
            wr(3'd0, 16'h0100 | {8'd0, VEC[k][15:9], 1'b0});
            wr(3'd0, 16'h0200 | {8'd0, VEC[k][8:1]});
            wait_done("R8 vector");
            rd(3'd1, v);
            chk("R8 vector status", v, 16'h0201 | (VEC[k][0] ? 16'h0004 : 16'h0));
            chk("R9 vector byte count", wcount, VEC[k][0] ? 0 : 1);
            if (!VEC[k][0]) chk("R3 vector byte value", wlog[0], VEC[k][8:1]);
            else            chk("R2 vector start count", n_start, 1);
        end

        // R7 phase lengths
        soft_reset();
        wr(3'd3, 16'd5); wr(3'd4, 16'd7);
        wr(3'd0, 16'h0100 | {8'd0, SADDR, 1'b0});
        wr(3'd0, 16'h0233);
        wait_done("R7");
        chk("R7 high phase cycles", hi_len, 5);
        chk("R7 low phase cycles", lo_len, 7);
        wr(3'd3, 16'd4); wr(3'd4, 16'd4);

        // R5 clear done
        wr(3'd1, 16'h0001);
        rd(3'd1, v); chk("R5 done cleared", v, 16'h0200);

        // R4 read with triggers carrying junk data
        soft_reset();
        wr(3'd0, 16'h0100 | {8'd0, SADDR, 1'b1});
        wr(3'd0, 16'h00FF);
        wr(3'd0, 16'h0055);
        wr(3'd0, 16'h0277);
        wait_done("R4");
        rd(3'd1, v); chk("R4 read status", v, 16'h0001);
        for (int i = 0; i < 3; i++) begin
            rd(3'd0, v); chk("R4 read byte", v, rd_pat(i));
        end
        chk("R4 ack first", mlog[0], 0);
        chk("R4 ack second", mlog[1], 0);
        chk("R4 nack on stop trigger", mlog[2], 1);
        rd(3'd0, v); chk("R10 drained rx reads zero", v, 0);
        rd(3'd1, v); chk("R10 rx empty after drain", v, 16'h0201);

        // R2 repeated start: write then read
        soft_reset();
        wr(3'd0, 16'h0100 | {8'd0, SADDR, 1'b0});
        wr(3'd0, 16'h0011);
        wr(3'd0, 16'h0100 | {8'd0, SADDR, 1'b1});
        wr(3'd0, 16'h0200);
        wait_done("R2");
        chk("R2 two starts", n_start, 2);
        chk("R2 written byte", wlog[0], 8'h11);
        rd(3'd0, v); chk("R2 read after repeated start", v, rd_pat(0));

        // R10 full transmit queue
        soft_reset();
        wr(3'd0, 16'h0100 | {8'd0, SADDR, 1'b0});
        wr(3'd0, 16'h00C1); wr(3'd0, 16'h00C2); wr(3'd0, 16'h00C3);
        wr(3'd0, 16'h02C4);
        rd(3'd1, v); chk("R10 tx full flag", v[10], 1);
        wr(3'd0, 16'h02EE);
        wait_done("R10");
        repeat (300) @(negedge clk);
        chk("R10 extra push dropped", wcount, 4);
        chk("R10 last byte kept", wlog[3], 8'hC4);
        chk("R10 no further start", n_start, 1);

        // R9 data nack drops queued entries
        soft_reset();
        force_nack = 1;
        wr(3'd0, 16'h0100 | {8'd0, SADDR, 1'b0});
        wr(3'd0, 16'h00D1); wr(3'd0, 16'h00D2); wr(3'd0, 16'h02D3);
        wait_done("R9");
        repeat (300) @(negedge clk);
        force_nack = 0;
        chk("R9 only first data byte on bus", wcount, 1);
        rd(3'd1, v); chk("R8 nack and done", v, 16'h0205);
        wr(3'd1, 16'h0001);
        rd(3'd1, v); chk("R8 nack sticky after done clear", v, 16'h0204);

        // R6 soft reset readback and clearing
        @(negedge clk); reg_wr = 1; reg_addr = 3'd2; reg_wdata = 16'h0100;
        @(negedge clk); reg_wr = 0; #1 chk("R6 busy bit set", reg_rdata, 16'h0100);
        @(negedge clk); #1 chk("R6 busy bit self-clears", reg_rdata, 0);
        rd(3'd1, v); chk("R6 status cleared", v, 16'h0200);

        // R6 soft reset in the middle of a byte
        wr(3'd3, 16'd20); wr(3'd4, 16'd20);
        wr(3'd0, 16'h0100 | {8'd0, SADDR, 1'b0});
        wr(3'd0, 16'h0000);
        repeat (150) @(negedge clk);
        wr(3'd2, 16'h0100);
        @(negedge clk);
        chk("R6 lines released mid-byte", {30'd0, scl_oe, sda_oe}, 0);
        rd(3'd1, v); chk("R6 queues empty mid-byte", v, 16'h0200);

        summary();
        $finish;
    end
endmodule